// File: doc/BRIEF.md
# Asynchronous Memory Strobe Controller

This block turns single requests from an internal master into timed cycles on an external asynchronous memory or peripheral. A request names the direction, an address, byte enables and, for writes, the data. The controller takes the request only while it is idle. It then runs the access through a setup phase, a strobe phase and a hold phase. The length of each phase comes from configuration inputs, with one set for reads and another set for writes.

During the strobe phase the external device can hold off completion by pulling a ready line low. That line passes through a two-flop synchronizer. The controller only looks at it near the end of the programmed strobe. When ready is seen low there, the strobe is stretched, and it ends a fixed two cycles after ready is seen high again. For reads, the memory data is registered on the final strobe cycle. A one-cycle completion pulse follows the hold phase.

Top module: `amc_async_ctrl`

## Requirements
- R1: An accepted access spends S cycles in setup, then T cycles in strobe, then H cycles in hold. S, T and H come from the read configuration inputs for reads and from the write configuration inputs for writes, so a read and a write can have different timing.
- R2: `mem_re_n` is low only during the strobe phase of a read, and `mem_we_n` is low only during the strobe phase of a write. The two are never low together.
- R3: From the first setup cycle through the last hold cycle, the following outputs are all held valid and unchanged: `mem_ce_n` low, `mem_addr` equal to the request address, and `mem_be_n` equal to the bitwise inverse of the request byte enables. `mem_oe_n` is low for a read and high for a write. `mem_wdata_en` is high for a write, with `mem_wdata` equal to the request data.
- R4: `mem_ready` reaches the strobe logic through a two-stage synchronizer. A level driven on it is first used by the controller two clocks after it is sampled.
- R5: A synchronized ready level seen while more than two programmed strobe cycles remain has no effect on the strobe length.
- R6: When synchronized ready is low in a strobe cycle that has at most two programmed cycles left, the strobe is extended cycle by cycle. Once synchronized ready is seen high again, that cycle and two more are the last strobe cycles.
- R7: On a read, `rd_data` takes the value of `mem_rdata` sampled on the last strobe cycle. It keeps that value until the next read completes its strobe.
- R8: `done` is high for exactly one cycle: the cycle after the last hold cycle. `busy` is high from the cycle after acceptance through the last hold cycle, and low when `done` is high.
- R9: A `req_valid` that arrives while `busy` is high is ignored. It does not change the address in progress and does not start a further access.
- R10: A programmed phase length of zero behaves as a length of one.
- R11: Asserting `rst_n` low returns the controller to idle at once. `mem_ce_n`, `mem_re_n` and `mem_we_n` go high, and `busy` and `done` go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_be | input | DW/8 | Request byte enables, active high |
| req_wdata | input | DW | Request write data |
| cfg_rd_setup | input | PW | Read setup length in cycles |
| cfg_rd_strobe | input | PW | Read strobe length in cycles |
| cfg_rd_hold | input | PW | Read hold length in cycles |
| cfg_wr_setup | input | PW | Write setup length in cycles |
| cfg_wr_strobe | input | PW | Write strobe length in cycles |
| cfg_wr_hold | input | PW | Write hold length in cycles |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DW | Captured read data |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_addr | output | AW | Memory address |
| mem_be_n | output | DW/8 | Byte enables, active low |
| mem_oe_n | output | 1 | Output enable for reads, active low |
| mem_re_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_wdata | output | DW | Write data bus |
| mem_wdata_en | output | 1 | Drive enable for the write data bus |
| mem_rdata | input | DW | Read data from memory |
| mem_ready | input | 1 | Asynchronous ready from memory, low to extend |

## Verification
Cycles are counted from the accept edge. The first setup cycle is index 0, the strobe starts at index S, hold starts at S plus the actual strobe length, and `done` appears at S+T+H. The bench samples every cycle on the falling edge and records the index of each transition. It compares those indices with values worked out by hand for each scenario.

A ready level driven in cycle j reaches the controller in cycle j+2. The stretched-strobe cases place ready edges relative to the window with that offset included. Read capture timing is checked by changing `mem_rdata` every cycle to a value tied to the cycle index. The captured word therefore identifies the exact cycle it was sampled in.

// File: rtl/amc_pkg.sv
package amc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;
endpackage

// File: rtl/amc_ready_sync.sv
module amc_ready_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= sync_d;
  end

  assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/amc_sequencer.sv
module amc_sequencer
  import amc_pkg::*;
#(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [PW-1:0] setup_cfg,
  input  logic [PW-1:0] strobe_cfg,
  input  logic [PW-1:0] hold_cfg,
  input  logic          rdy_sync,
  output phase_e        phase,
  output logic          capture,
  output logic          done
);
  localparam logic [PW-1:0] ONE = PW'(1);
  localparam logic [PW-1:0] WIN = PW'(2);

  phase_e        ph_q, ph_d;
  logic [PW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] stb_q, hld_q;
  logic          done_q, done_d;
  logic          len_ld;

  function automatic logic [PW-1:0] at_least_one(input logic [PW-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  always_comb begin
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    capture = 1'b0;
    len_ld  = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_d   = PH_SETUP;
          cnt_d  = at_least_one(setup_cfg) - ONE;
          len_ld = 1'b1;
        end
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          ph_d  = PH_STROBE;
          cnt_d = stb_q - ONE;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      PH_STROBE: begin
        // inside the last-three-cycle window a low ready parks the count
        if ((cnt_q <= WIN) && !rdy_sync) begin
          cnt_d = WIN;
        end else if (cnt_q == '0) begin
          ph_d    = PH_HOLD;
          cnt_d   = hld_q - ONE;
          capture = 1'b1;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      PH_HOLD: begin
        if (cnt_q == '0) begin
          ph_d   = PH_IDLE;
          done_d = 1'b1;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= ONE;
      hld_q <= ONE;
    end else if (len_ld) begin
      stb_q <= at_least_one(strobe_cfg);
      hld_q <= at_least_one(hold_cfg);
    end
  end

  assign phase = ph_q;
  assign done  = done_q;
endmodule

// File: rtl/amc_access_regs.sv
module amc_access_regs #(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          wr_in,
  input  logic [AW-1:0] addr_in,
  input  logic [BW-1:0] be_in,
  input  logic [DW-1:0] wdata_in,
  input  logic          capture,
  input  logic [DW-1:0] rdata_in,
  output logic          wr_q,
  output logic [AW-1:0] addr_q,
  output logic [BW-1:0] be_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q
);
  logic cap_en;

  always_comb cap_en = capture && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
    end else if (load) begin
      wr_q    <= wr_in;
      addr_q  <= addr_in;
      be_q    <= be_in;
      wdata_q <= wdata_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_en) rdata_q <= rdata_in;
  end
endmodule

// File: rtl/amc_async_ctrl.sv
module amc_async_ctrl
  import amc_pkg::*;
#(
  parameter int AW          = 20,
  parameter int DW          = 16,
  parameter int PW          = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW/8-1:0]  req_be,
  input  logic [DW-1:0]    req_wdata,
  input  logic [PW-1:0]    cfg_rd_setup,
  input  logic [PW-1:0]    cfg_rd_strobe,
  input  logic [PW-1:0]    cfg_rd_hold,
  input  logic [PW-1:0]    cfg_wr_setup,
  input  logic [PW-1:0]    cfg_wr_strobe,
  input  logic [PW-1:0]    cfg_wr_hold,
  output logic             busy,
  output logic             done,
  output logic [DW-1:0]    rd_data,
  output logic             mem_ce_n,
  output logic [AW-1:0]    mem_addr,
  output logic [DW/8-1:0]  mem_be_n,
  output logic             mem_oe_n,
  output logic             mem_re_n,
  output logic             mem_we_n,
  output logic [DW-1:0]    mem_wdata,
  output logic             mem_wdata_en,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_ready
);
  localparam int BW = DW / 8;

  phase_e        phase;
  logic          rdy_sync;
  logic          accept;
  logic          capture;
  logic          active;
  logic          wr_q;
  logic [BW-1:0] be_q;
  logic [PW-1:0] sel_setup, sel_strobe, sel_hold;

  always_comb begin
    accept     = req_valid && (phase == PH_IDLE);
    sel_setup  = req_write ? cfg_wr_setup  : cfg_rd_setup;
    sel_strobe = req_write ? cfg_wr_strobe : cfg_rd_strobe;
    sel_hold   = req_write ? cfg_wr_hold   : cfg_rd_hold;
  end

  amc_ready_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (mem_ready),
    .dout (rdy_sync)
  );

  amc_sequencer #(.PW(PW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .setup_cfg (sel_setup),
    .strobe_cfg(sel_strobe),
    .hold_cfg  (sel_hold),
    .rdy_sync  (rdy_sync),
    .phase     (phase),
    .capture   (capture),
    .done      (done)
  );

  amc_access_regs #(.AW(AW), .DW(DW), .BW(BW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .wr_in   (req_write),
    .addr_in (req_addr),
    .be_in   (req_be),
    .wdata_in(req_wdata),
    .capture (capture),
    .rdata_in(mem_rdata),
    .wr_q    (wr_q),
    .addr_q  (mem_addr),
    .be_q    (be_q),
    .wdata_q (mem_wdata),
    .rdata_q (rd_data)
  );

  always_comb begin
    active       = (phase != PH_IDLE);
    busy         = active;
    mem_ce_n     = !active;
    mem_be_n     = active ? ~be_q : '1;
    mem_oe_n     = !(active && !wr_q);
    mem_wdata_en = active && wr_q;
    mem_re_n     = !((phase == PH_STROBE) && !wr_q);
    mem_we_n     = !((phase == PH_STROBE) && wr_q);
  end
endmodule

// File: rtl/amc_async_ctrl_chk.sv
module amc_async_ctrl_chk #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          busy,
  input logic          done,
  input logic          mem_ce_n,
  input logic          mem_re_n,
  input logic          mem_we_n,
  input logic          rdy_sync,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] rd_data
);
  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_re_n && !mem_we_n));

  p_strobe_in_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_re_n || !mem_we_n) |-> !mem_ce_n);

  p_addr_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

  p_release_needs_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_re_n) || $rose(mem_we_n)) |-> $past(rdy_sync));

  p_rdata_on_strobe_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> $rose(mem_re_n));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && mem_ce_n));

  p_busy_ignores_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> $stable(mem_addr));
endmodule

bind amc_async_ctrl amc_async_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .busy     (busy),
  .done     (done),
  .mem_ce_n (mem_ce_n),
  .mem_re_n (mem_re_n),
  .mem_we_n (mem_we_n),
  .rdy_sync (rdy_sync),
  .mem_addr (mem_addr),
  .rd_data  (rd_data)
);

// File: tb/tb_amc_async_ctrl.sv
`timescale 1ns/1ps
module tb_amc_async_ctrl;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int PW = 4;
  localparam int BW = DW / 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [BW-1:0] req_be;
  logic [DW-1:0] req_wdata;
  logic [PW-1:0] cfg_rd_setup, cfg_rd_strobe, cfg_rd_hold;
  logic [PW-1:0] cfg_wr_setup, cfg_wr_strobe, cfg_wr_hold;
  logic          busy, done;
  logic [DW-1:0] rd_data;
  logic          mem_ce_n, mem_oe_n, mem_re_n, mem_we_n, mem_wdata_en;
  logic [AW-1:0] mem_addr;
  logic [BW-1:0] mem_be_n;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          mem_ready;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  amc_async_ctrl #(.AW(AW), .DW(DW), .PW(PW)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata),
    .cfg_rd_setup(cfg_rd_setup), .cfg_rd_strobe(cfg_rd_strobe), .cfg_rd_hold(cfg_rd_hold),
    .cfg_wr_setup(cfg_wr_setup), .cfg_wr_strobe(cfg_wr_strobe), .cfg_wr_hold(cfg_wr_hold),
    .busy(busy), .done(done), .rd_data(rd_data),
    .mem_ce_n(mem_ce_n), .mem_addr(mem_addr), .mem_be_n(mem_be_n), .mem_oe_n(mem_oe_n),
    .mem_re_n(mem_re_n), .mem_we_n(mem_we_n), .mem_wdata(mem_wdata),
    .mem_wdata_en(mem_wdata_en), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One access. Index 0 is the first cycle after the accept edge.
  // mem_ready is driven low for indices in [lo_from, lo_until); -1 = before the request.
  task automatic run_access(input logic wr, input logic [AW-1:0] a, input logic [BW-1:0] be,
                            input logic [DW-1:0] wd, input int s_exp, input int t_exp,
                            input int h_exp, input int lo_from, input int lo_until,
                            input string len_req);
    int first_stb = -1;
    int n_stb     = 0;
    int last_stb  = -1;
    int done_at   = -1;
    int bad_sel   = 0;
    int bad_other = 0;
    int bad_busy  = 0;
    @(negedge clk);
    mem_ready = !(-1 >= lo_from && -1 < lo_until);
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
    mem_rdata = 16'hA000;
    for (int j = 0; j < 300 && done_at < 0; j++) begin
      @(negedge clk);
      if (done) begin
        done_at = j;
        check(mem_ce_n && !busy, "R8", "idle outputs with done", int'(mem_ce_n), 1);
      end else begin
        if (wr ? !mem_we_n : !mem_re_n) begin
          if (first_stb < 0) first_stb = j;
          n_stb++;
          last_stb = j;
        end
        if (wr ? !mem_re_n : !mem_we_n) bad_other++;
        if (mem_ce_n || mem_addr != a || mem_be_n != ~be || mem_oe_n != wr ||
            mem_wdata_en != wr || (wr && mem_wdata != wd)) bad_sel++;
        if (!busy) bad_busy++;
      end
      // stimulus for this cycle
      req_valid = (j == 1);
      req_addr  = (j == 1) ? ~a : a;
      mem_ready = !(j >= lo_from && j < lo_until);
      mem_rdata = 16'hA000 + DW'(j);
    end
    req_valid = 1'b0;
    mem_ready = 1'b1;
    check(first_stb == s_exp, "R1", "strobe start index", first_stb, s_exp);
    check(n_stb == t_exp, len_req, "strobe length", n_stb, t_exp);
    check(last_stb == first_stb + n_stb - 1, "R2", "strobe contiguous end", last_stb,
          first_stb + n_stb - 1);
    check(bad_other == 0, "R2", "wrong-direction strobe cycles", bad_other, 0);
    check(done_at == s_exp + t_exp + h_exp, "R8", "done index", done_at, s_exp + t_exp + h_exp);
    check(bad_sel == 0, "R3", "select mismatch cycles", bad_sel, 0);
    check(bad_busy == 0, "R8", "busy low during access", bad_busy, 0);
    if (!wr)
      check(rd_data == 16'hA000 + DW'(s_exp + t_exp - 1), "R7", "captured read data",
            int'(rd_data), 32'hA000 + s_exp + t_exp - 1);
    @(negedge clk);
    check(!done, "R8", "done width", int'(done), 0);
    check(mem_ce_n && !busy, "R9", "no access from request while busy", int'(mem_ce_n), 1);
  endtask

  task automatic t_reset_state();
    check(mem_ce_n && mem_re_n && mem_we_n, "R11", "strobes/ce after reset",
          int'({mem_ce_n, mem_re_n, mem_we_n}), 7);
    check(!busy && !done, "R11", "busy/done after reset", int'({busy, done}), 0);
  endtask

  task automatic t_read_basic();
    cfg_rd_setup = 2; cfg_rd_strobe = 3; cfg_rd_hold = 2;
    cfg_wr_setup = 1; cfg_wr_strobe = 5; cfg_wr_hold = 3;
    run_access(1'b0, 20'h1_2345, 2'b11, 16'h0, 2, 3, 2, 0, 0, "R1");
  endtask

  task automatic t_write_basic();
    // write uses its own timing set (1,5,3) while read set stays (2,3,2)
    run_access(1'b1, 20'h0_0F0F, 2'b01, 16'hBEEF, 1, 5, 3, 0, 0, "R1");
  endtask

  task automatic t_zero_lengths();
    cfg_rd_setup = 0; cfg_rd_strobe = 0; cfg_rd_hold = 0;
    run_access(1'b0, 20'hF_0001, 2'b10, 16'h0, 1, 1, 1, 0, 0, "R10");
  endtask

  task automatic t_early_ready_ignored();
    // strobe 6: window starts at index 4; sync ready low only at indices 1..3
    cfg_rd_setup = 1; cfg_rd_strobe = 6; cfg_rd_hold = 1;
    run_access(1'b0, 20'h0_5555, 2'b11, 16'h0, 1, 6, 1, -1, 2, "R5");
  endtask

  task automatic t_read_extended();
    // ready high driven at index 5 -> seen at 7 -> strobe ends at 9 (length 9)
    cfg_rd_setup = 1; cfg_rd_strobe = 4; cfg_rd_hold = 1;
    run_access(1'b0, 20'h3_3333, 2'b11, 16'h0, 1, 9, 1, -1, 5, "R6");
  endtask

  task automatic t_write_last_cycle_low();
    // low driven at index 1 reaches the last strobe cycle (index 3) via two flops;
    // high seen at 4 -> strobe ends at 6 (length 5)
    run_access(1'b1, 20'h4_4444, 2'b10, 16'h1234, 1, 5, 3, 0, 0, "R1");
    cfg_wr_setup = 2; cfg_wr_strobe = 2; cfg_wr_hold = 1;
    run_access(1'b1, 20'h7_7777, 2'b11, 16'hCAFE, 2, 5, 1, 1, 2, "R4");
  endtask

  task automatic t_async_reset();
    cfg_rd_setup = 1; cfg_rd_strobe = 8; cfg_rd_hold = 1;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 20'h0_0ABC;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(!mem_re_n, "R11", "read strobe active before reset", int'(mem_re_n), 0);
    rst_n = 1'b0;
    #1;
    check(mem_ce_n && mem_re_n && mem_we_n && !busy && !done, "R11",
          "immediate idle on reset", int'({mem_ce_n, mem_re_n, mem_we_n, busy, done}), 28);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_be = '0; req_wdata = '0;
    cfg_rd_setup = 1; cfg_rd_strobe = 1; cfg_rd_hold = 1;
    cfg_wr_setup = 1; cfg_wr_strobe = 1; cfg_wr_hold = 1;
    mem_rdata = '0; mem_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_read_basic();
    t_write_basic();
    t_zero_lengths();
    t_early_ready_ignored();
    t_read_extended();
    t_write_last_cycle_low();
    t_async_reset();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule